// File: doc/BRIEF.md
# Interval Timer Programming Write Path

This block is the write side of a three-channel programmable interval timer. Every bus write carries an 8-bit byte and a 2-bit address. Addresses 0, 1 and 2 carry count bytes to channels 0, 1 and 2. Address 3 carries a command byte. The block decodes that command byte in one of three ways: as a channel programming word, as a counter latch request, or as a read-back request.

For each channel the block stores the programmed operating mode, the byte access format and the BCD flag. It assembles the channel's 16-bit initial count from one or two bytes, following the stored format. It raises one-cycle strobes when a programming word lands and when a count is complete. It drives the level that the channel output takes right after programming, and it keeps a per-channel pending-count flag. This flag clears when the counting logic reports that it has taken the count.

Latch and read-back commands do not change any channel state here. They leave as one-cycle latch pulses for the read-side logic.

Top module: `tmr_wr_seq`

## Requirements
- R1: After reset, every channel shows mode 0, format 00, BCD 0, count 0, output level 0 and pending flag 0, and every strobe and latch pulse is low.
- R2: A write with address 0, 1 or 2 is a count byte for that channel only. A write with address 3 is a command byte. All outputs are registered, so a write sampled at a rising edge is visible after that edge.
- R3: In a command byte, bits 7:6 pick the channel (00, 01, 10), bits 5:4 pick the format (01 low byte only, 10 high byte only, 11 low then high), bits 3:1 pick the mode and bit 0 is the BCD flag. A programming word stores these fields and pulses that channel's ctrl_wr_p for one cycle.
- R4: A programming word sets the channel's output level to 0 for mode 0 and to 1 for any other mode.
- R5: In format 01, a byte b gives the count {8'h00, b} and pulses new_cnt_p for one cycle.
- R6: In format 10, a byte b gives the count {b, 8'h00} and pulses new_cnt_p for one cycle.
- R7: In format 11, the first byte replaces the low half of the count without a new_cnt_p pulse. The second byte replaces the high half and pulses new_cnt_p.
- R8: A programming word sends the channel's format-11 byte order back to "low byte next".
- R9: Count bytes sent to a channel whose stored format is 00 (never programmed) have no effect: the count stays the same and no new_cnt_p pulse occurs.
- R10: A command byte with bits 7:6 below 11 and bits 5:4 = 00 is a latch request. It pulses cnt_latch_p for that channel for one cycle and leaves the channel's mode, format and ctrl_wr_p unchanged.
- R11: A command byte with bits 7:6 = 11 is a read-back request. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 pulses cnt_latch_p for the selected channels, and bit 4 = 0 pulses sts_latch_p for them. No channel programming changes.
- R12: A channel's pending flag is set by a programming word or an accepted count byte. It is cleared by an xfer_done pulse on that channel. When a write and xfer_done arrive in the same cycle, the write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 2 | Write address (0-2 channel, 3 command) |
| wr_data | input | 8 | Write data byte |
| xfer_done | input | 3 | Per-channel pulse: count taken by counting logic |
| ch_mode | output | 9 | Mode of channel i at bits [3i+2:3i] |
| ch_fmt | output | 6 | Access format of channel i at bits [2i+1:2i] |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_count | output | 48 | Count of channel i at bits [16i+15:16i] |
| ch_out_lvl | output | 3 | Output level set by programming |
| ch_null | output | 3 | Pending-count flag per channel |
| new_cnt_p | output | 3 | Count-complete strobe per channel |
| ctrl_wr_p | output | 3 | Programming-word strobe per channel |
| cnt_latch_p | output | 3 | Count latch pulse per channel |
| sts_latch_p | output | 3 | Status latch pulse per channel |

## Verification
The assertions assume that address and data are valid whenever wr_en is high, and that at most one write occurs per cycle. They also assume xfer_done is a plain per-channel pulse that may coincide with a write. The bench changes inputs only on the falling clock edge. Each write lasts exactly one cycle. Every command byte it sends is one of the encodings listed under R3, R10 and R11, so every write falls into exactly one decoded class.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH = 3;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_BOTH = 2'b11
  } fmt_e;

  // Level the channel output takes right after a programming word
  function automatic logic prog_level(input logic [MODE_W-1:0] m);
    return (m != '0);
  endfunction
endpackage

// File: rtl/tmr_wr_dec.sv
module tmr_wr_dec
  import tmr_pkg::*;
#(
  parameter int N_CH = NUM_CH,
  parameter int D_W  = DATA_W,
  parameter int A_W  = ADDR_W
) (
  input  logic           wr_en,
  input  logic [A_W-1:0] wr_addr,
  input  logic [D_W-1:0] wr_data,
  output logic [N_CH-1:0] prog_w,
  output logic [N_CH-1:0] byte_w,
  output logic [N_CH-1:0] lat_cnt,
  output logic [N_CH-1:0] lat_sts
);
  localparam logic [A_W-1:0] CMD_ADDR = A_W'(N_CH);
  localparam logic [1:0]     RB_SEL   = 2'b11;

  logic       is_cmd;
  logic [1:0] sel;
  logic [1:0] fmt;
  logic       is_rb;

  assign is_cmd = wr_en && (wr_addr == CMD_ADDR);
  assign sel    = wr_data[D_W-1 -: 2];
  assign fmt    = wr_data[D_W-3 -: 2];
  assign is_rb  = is_cmd && (sel == RB_SEL);

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    logic hit;
    assign hit        = is_cmd && !is_rb && (sel == 2'(i));
    assign prog_w[i]  = hit && (fmt != 2'b00);
    assign byte_w[i]  = wr_en && (wr_addr == A_W'(i));
    assign lat_cnt[i] = (hit && (fmt == 2'b00)) ||
                        (is_rb && !wr_data[5] && wr_data[i+1]);
    assign lat_sts[i] = is_rb && !wr_data[4] && wr_data[i+1];
  end
endmodule

// File: rtl/tmr_chan_prog.sv
module tmr_chan_prog
  import tmr_pkg::*;
#(
  parameter int D_W = DATA_W,
  parameter int M_W = MODE_W,
  localparam int C_W = 2 * D_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prog_w,
  input  logic [M_W-1:0] mode_in,
  input  fmt_e           fmt_in,
  input  logic           bcd_in,
  input  logic           byte_w,
  input  logic [D_W-1:0] byte_d,
  input  logic           xfer,
  output logic [M_W-1:0] mode_q,
  output fmt_e           fmt_q,
  output logic           bcd_q,
  output logic [C_W-1:0] count_q,
  output logic           out_lvl_q,
  output logic           null_q,
  output logic           new_p,
  output logic           ctrl_p
);
  logic hi_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      fmt_q     <= FMT_NONE;
      bcd_q     <= 1'b0;
      count_q   <= '0;
      out_lvl_q <= 1'b0;
      null_q    <= 1'b0;
      new_p     <= 1'b0;
      ctrl_p    <= 1'b0;
      hi_next   <= 1'b0;
    end else begin
      new_p  <= 1'b0;
      ctrl_p <= 1'b0;
      if (xfer) null_q <= 1'b0;
      if (prog_w) begin
        mode_q    <= mode_in;
        fmt_q     <= fmt_in;
        bcd_q     <= bcd_in;
        out_lvl_q <= prog_level(mode_in);
        hi_next   <= 1'b0;
        null_q    <= 1'b1;
        ctrl_p    <= 1'b1;
      end else if (byte_w && fmt_q != FMT_NONE) begin
        null_q <= 1'b1;
        unique case (fmt_q)
          FMT_LO: begin
            count_q <= {{D_W{1'b0}}, byte_d};
            new_p   <= 1'b1;
          end
          FMT_HI: begin
            count_q <= {byte_d, {D_W{1'b0}}};
            new_p   <= 1'b1;
          end
          default: begin
            if (hi_next) begin
              count_q[C_W-1:D_W] <= byte_d;
              new_p              <= 1'b1;
            end else begin
              count_q[D_W-1:0] <= byte_d;
            end
            hi_next <= !hi_next;
          end
        endcase
      end
    end
  end

  // R4
  out_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_p |-> (out_lvl_q == (mode_q != '0)));

  // R7
  first_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_w && !prog_w && fmt_q == FMT_BOTH && !hi_next) |=> (!new_p && hi_next));

  // R8
  order_reset_chk: assert property (@(posedge clk) disable iff (rst)
    prog_w |=> !hi_next);

  // R9
  unprog_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_w && !prog_w && fmt_q == FMT_NONE) |=> (!new_p && $stable(count_q)));

  // R12
  null_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !prog_w && !byte_w) |=> !null_q);

  // R12
  null_set_chk: assert property (@(posedge clk) disable iff (rst)
    prog_w |=> null_q);
endmodule

// File: rtl/tmr_wr_seq.sv
module tmr_wr_seq
  import tmr_pkg::*;
#(
  parameter int N_CH = NUM_CH,
  parameter int D_W  = DATA_W,
  parameter int A_W  = ADDR_W,
  parameter int M_W  = MODE_W,
  localparam int C_W = 2 * D_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [A_W-1:0]      wr_addr,
  input  logic [D_W-1:0]      wr_data,
  input  logic [N_CH-1:0]     xfer_done,
  output logic [N_CH*M_W-1:0] ch_mode,
  output logic [N_CH*2-1:0]   ch_fmt,
  output logic [N_CH-1:0]     ch_bcd,
  output logic [N_CH*C_W-1:0] ch_count,
  output logic [N_CH-1:0]     ch_out_lvl,
  output logic [N_CH-1:0]     ch_null,
  output logic [N_CH-1:0]     new_cnt_p,
  output logic [N_CH-1:0]     ctrl_wr_p,
  output logic [N_CH-1:0]     cnt_latch_p,
  output logic [N_CH-1:0]     sts_latch_p
);
  logic [N_CH-1:0] prog_w, byte_w, lat_cnt, lat_sts;

  tmr_wr_dec #(.N_CH(N_CH), .D_W(D_W), .A_W(A_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .prog_w  (prog_w),
    .byte_w  (byte_w),
    .lat_cnt (lat_cnt),
    .lat_sts (lat_sts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_latch_p <= '0;
      sts_latch_p <= '0;
    end else begin
      cnt_latch_p <= lat_cnt;
      sts_latch_p <= lat_sts;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    fmt_e fmt_o;
    tmr_chan_prog #(.D_W(D_W), .M_W(M_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .prog_w    (prog_w[i]),
      .mode_in   (wr_data[M_W:1]),
      .fmt_in    (fmt_e'(wr_data[5:4])),
      .bcd_in    (wr_data[0]),
      .byte_w    (byte_w[i]),
      .byte_d    (wr_data),
      .xfer      (xfer_done[i]),
      .mode_q    (ch_mode[i*M_W +: M_W]),
      .fmt_q     (fmt_o),
      .bcd_q     (ch_bcd[i]),
      .count_q   (ch_count[i*C_W +: C_W]),
      .out_lvl_q (ch_out_lvl[i]),
      .null_q    (ch_null[i]),
      .new_p     (new_cnt_p[i]),
      .ctrl_p    (ctrl_wr_p[i])
    );
    assign ch_fmt[i*2 +: 2] = fmt_o;
  end

  // R2
  one_class_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|prog_w, |byte_w, |lat_cnt | |lat_sts}));

  // R3
  one_prog_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_wr_p));

  // R10
  latch_no_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (|cnt_latch_p || |sts_latch_p) |-> (ctrl_wr_p == '0 && new_cnt_p == '0));

  // R11
  latch_keeps_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (|lat_cnt || |lat_sts) |=> $stable(ch_fmt) && $stable(ch_mode));
endmodule

// File: tb/tmr_wr_seq_tb.sv
module tmr_wr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [2:0]  xfer_done;
  logic [8:0]  ch_mode;
  logic [5:0]  ch_fmt;
  logic [2:0]  ch_bcd;
  logic [47:0] ch_count;
  logic [2:0]  ch_out_lvl, ch_null, new_cnt_p, ctrl_wr_p, cnt_latch_p, sts_latch_p;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_wr_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xfer_done(xfer_done), .ch_mode(ch_mode), .ch_fmt(ch_fmt), .ch_bcd(ch_bcd),
    .ch_count(ch_count), .ch_out_lvl(ch_out_lvl), .ch_null(ch_null),
    .new_cnt_p(new_cnt_p), .ctrl_wr_p(ctrl_wr_p), .cnt_latch_p(cnt_latch_p),
    .sts_latch_p(sts_latch_p)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  // One-cycle write; on return the registered result is visible
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [2:0] xf = 3'b000);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; xfer_done = xf;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = 3'b000;
  endtask

  function automatic logic [15:0] cnt(input int c);
    return ch_count[c*16 +: 16];
  endfunction

  task automatic t_reset();
    cmp("R1 mode", ch_mode, 0);
    cmp("R1 fmt", ch_fmt, 0);
    cmp("R1 count", ch_count, 0);
    cmp("R1 levels", {ch_bcd, ch_out_lvl, ch_null}, 0);
    cmp("R1 strobes", {new_cnt_p, ctrl_wr_p, cnt_latch_p, sts_latch_p}, 0);
  endtask

  task automatic t_unprog();
    wr(2'd1, 8'h5A);
    cmp("R9 count unchanged", cnt(1), 16'h0000);
    cmp("R9 no new strobe", new_cnt_p, 3'b000);
    cmp("R9 null untouched", ch_null, 3'b000);
  endtask

  task automatic t_lsb();
    wr(2'd3, 8'h16);                 // ch0, fmt 01, mode 3, binary
    cmp("R3 ctrl strobe ch0", ctrl_wr_p, 3'b001);
    cmp("R3 mode ch0", ch_mode[2:0], 3);
    cmp("R3 fmt ch0", ch_fmt[1:0], 2'b01);
    cmp("R4 level high mode3", ch_out_lvl[0], 1);
    wr(2'd0, 8'h50);
    cmp("R5 count", cnt(0), 16'h0050);
    cmp("R5 new strobe", new_cnt_p, 3'b001);
    cmp("R2 other counts", {cnt(1), cnt(2)}, 0);
    @(negedge clk);
    cmp("R5 strobe one cycle", new_cnt_p, 3'b000);
  endtask

  task automatic t_msb();
    wr(2'd3, 8'h61);                 // ch1, fmt 10, mode 0, BCD
    cmp("R3 ctrl strobe ch1", ctrl_wr_p, 3'b010);
    cmp("R3 bcd ch1", ch_bcd, 3'b010);
    cmp("R4 level low mode0", ch_out_lvl[1], 0);
    wr(2'd1, 8'h12);
    cmp("R6 count", cnt(1), 16'h1200);
    cmp("R6 new strobe", new_cnt_p, 3'b010);
  endtask

  task automatic t_both();
    wr(2'd3, 8'hB4);                 // ch2, fmt 11, mode 2
    cmp("R4 level high mode2", ch_out_lvl[2], 1);
    wr(2'd2, 8'hE8);
    cmp("R7 low byte", cnt(2), 16'h00E8);
    cmp("R7 no strobe after first", new_cnt_p, 3'b000);
    wr(2'd2, 8'h03);
    cmp("R7 full count", cnt(2), 16'h03E8);
    cmp("R7 strobe after second", new_cnt_p, 3'b100);
  endtask

  task automatic t_order_reset();
    wr(2'd2, 8'h11);                 // low byte, high expected next
    wr(2'd3, 8'hB4);                 // reprogram
    wr(2'd2, 8'h22);
    cmp("R8 low byte again", cnt(2), 16'h0322);
    cmp("R8 no strobe", new_cnt_p, 3'b000);
    wr(2'd2, 8'h33);
    cmp("R8 high byte", cnt(2), 16'h3322);
    cmp("R8 strobe", new_cnt_p, 3'b100);
  endtask

  task automatic t_latch();
    wr(2'd3, 8'h40);                 // latch request ch1
    cmp("R10 latch pulse", cnt_latch_p, 3'b010);
    cmp("R10 no ctrl strobe", ctrl_wr_p, 3'b000);
    cmp("R10 fmt kept", ch_fmt[3:2], 2'b10);
    cmp("R10 no status pulse", sts_latch_p, 3'b000);
    @(negedge clk);
    cmp("R10 one cycle", cnt_latch_p, 3'b000);
  endtask

  task automatic t_readback();
    wr(2'd3, 8'hCA);                 // count+status, ch0 and ch2
    cmp("R11 count latch", cnt_latch_p, 3'b101);
    cmp("R11 status latch", sts_latch_p, 3'b101);
    cmp("R11 no ctrl", ctrl_wr_p, 3'b000);
    cmp("R11 fmt kept", ch_fmt, 6'b11_10_01);
    wr(2'd3, 8'hDE);                 // count only, all channels
    cmp("R11 count all", cnt_latch_p, 3'b111);
    cmp("R11 status none", sts_latch_p, 3'b000);
  endtask

  task automatic t_null();
    cmp("R12 set after writes", ch_null, 3'b111);
    @(negedge clk); xfer_done = 3'b001;
    @(negedge clk); xfer_done = 3'b000;
    cmp("R12 cleared ch0", ch_null, 3'b110);
    wr(2'd0, 8'h07, 3'b001);
    cmp("R12 write wins", ch_null[0], 1);
    cmp("R5 count after", cnt(0), 16'h0007);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; xfer_done = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unprog();
    t_lsb();
    t_msb();
    t_both();
    t_order_reset();
    t_latch();
    t_readback();
    t_null();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule